// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard logic of a single-issue integer pipeline with five stages: fetch, decode, execute, memory and write-back. It is purely combinational. It looks at the instruction in the fetch/decode register, and at the destination numbers, write enables and load flags held in the three later pipeline registers. From these it computes the operand bypass selects for the ALU, a bypass select for the branch compare in decode, a hold for the PC and the fetch/decode register, a no-op insert into the decode/execute register, and a branch redirect.

Registers are read only in decode and written only in write-back. Because of this, the only hazard to handle is a read that comes after a write. Most such hazards are removed by forwarding. A load followed at once by a consumer of its result costs one bubble. A branch is resolved in decode and has one delay slot. The instruction in that slot always runs, so there is no flush output. A branch whose compare register is still being produced waits in decode until the value can be bypassed to it.

Instruction fields used: opcode in bits 31:26, first source in bits 25:21, second source in bits 20:16. Opcode classes:
- 6'h00: register-register. Reads both sources.
- 6'h2B: store. Reads both sources.
- 6'h04 and 6'h05: branch on zero or non-zero. Reads the first source only.
- 6'h02 and 6'h03: jump. Reads no register.
- Any other opcode: reads the first source only.

Top module: `hazard_ctl`

## Requirements
- R1: `fwd_a` is 2'b01 (take the EX/MEM result) when `mem_we`=1, `mem_load`=0, and `mem_rd` equals `ex_rs1`, which is non-zero.
- R2: Otherwise `fwd_a` is 2'b10 (take the MEM/WB value) when `wb_we`=1 and `wb_rd` equals a non-zero `ex_rs1`. In every other case `fwd_a` is 2'b00 (register file).
- R3: When both the EX/MEM and the MEM/WB conditions hold for the same source, the EX/MEM select 2'b01 wins.
- R4: `fwd_b` follows the same rules as R1 to R3, applied to `ex_rs2`.
- R5: A destination of register 0 never produces a forwarding select other than 2'b00. It never causes a stall.
- R6: A load-use interlock raises `stall` and `bubble` together. It applies when `ex_load`=1, `ex_we`=1, and `ex_rd` is non-zero and equals a source that the decode instruction reads.
- R7: A register field that the decode instruction does not read never causes a stall. Examples: bits 20:16 of a register-immediate instruction, or any field of a jump.
- R8: A branch in decode (opcode 6'h04 or 6'h05) raises `stall` and `bubble` in two cases. The first is when `ex_we`=1 and `ex_rd` equals its non-zero first source. The second is when a load in MEM (`mem_load`=1, `mem_we`=1) writes that register.
- R9: `fwd_z` selects the value for the branch compare in decode. It gives 2'b01 from EX/MEM (a non-load writer) and 2'b10 from MEM/WB, with the same priority and register-0 rule as R1 to R3.
- R10: `redirect` is 1 only when a branch is in decode, `id_cond_met`=1 and `stall`=0. It never raises `stall`, so the already fetched delay-slot instruction proceeds.
- R11: `stall` and `bubble` are always equal. With no hazard, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction held in the fetch/decode register |
| id_cond_met | input | 1 | Branch compare outcome from decode (1 = branch taken) |
| ex_rs1 | input | 5 | First source of the instruction in execute |
| ex_rs2 | input | 5 | Second source of the instruction in execute |
| ex_rd | input | 5 | Destination of the instruction in execute |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination held in EX/MEM |
| mem_we | input | 1 | EX/MEM write enable |
| mem_load | input | 1 | EX/MEM holds a load |
| wb_rd | input | 5 | Destination held in MEM/WB |
| wb_we | input | 1 | MEM/WB write enable |
| fwd_a | output | 2 | ALU operand A select: 00 file, 01 EX/MEM, 10 MEM/WB |
| fwd_b | output | 2 | ALU operand B select, same encoding |
| fwd_z | output | 2 | Branch compare operand select, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Load a no-op (write enable clear) into decode/execute |
| redirect | output | 1 | Steer fetch to the branch target after the delay slot |

## Verification
Some hazards can occur in the same cycle. Forwarding for the instruction in execute can coincide with an interlock for the instruction in decode. A branch whose condition is met can coincide with a pending write to its compare register. The bench provokes both pairings. It uses directed cases and random register numbers drawn from a small pool, so that matches are frequent. In every such cycle it checks two things: the forwarding selects are unaffected by the stall, and `redirect` stays low while `stall` is high.

// File: rtl/hazard_ctl.sv
module hazard_ctl (
  input  logic [31:0] id_instr,
  input  logic        id_cond_met,
  input  logic [4:0]  ex_rs1,
  input  logic [4:0]  ex_rs2,
  input  logic [4:0]  ex_rd,
  input  logic        ex_we,
  input  logic        ex_load,
  input  logic [4:0]  mem_rd,
  input  logic        mem_we,
  input  logic        mem_load,
  input  logic [4:0]  wb_rd,
  input  logic        wb_we,
  output logic [1:0]  fwd_a,
  output logic [1:0]  fwd_b,
  output logic [1:0]  fwd_z,
  output logic        stall,
  output logic        bubble,
  output logic        redirect
);
  localparam logic [5:0] OP_RR  = 6'h00;
  localparam logic [5:0] OP_ST  = 6'h2B;
  localparam logic [5:0] OP_BZ  = 6'h04;
  localparam logic [5:0] OP_BNZ = 6'h05;
  localparam logic [5:0] OP_J   = 6'h02;
  localparam logic [5:0] OP_JL  = 6'h03;

  logic [5:0] op;
  logic [4:0] src1, src2;
  logic       reads1, reads2, is_br, load_use, br_wait;

  assign op     = id_instr[31:26];
  assign src1   = id_instr[25:21];
  assign src2   = id_instr[20:16];
  assign is_br  = (op == OP_BZ) || (op == OP_BNZ);
  assign reads1 = (op != OP_J) && (op != OP_JL);
  assign reads2 = (op == OP_RR) || (op == OP_ST);

  function automatic logic [1:0] pick(input logic [4:0] src);
    if (src != 5'd0 && mem_we && !mem_load && mem_rd == src) return 2'b01;
    if (src != 5'd0 && wb_we && wb_rd == src)                return 2'b10;
    return 2'b00;
  endfunction

  assign fwd_a = pick(ex_rs1);
  assign fwd_b = pick(ex_rs2);
  assign fwd_z = pick(src1);

  assign load_use = ex_load && ex_we && ex_rd != 5'd0 &&
                    ((reads1 && ex_rd == src1) || (reads2 && ex_rd == src2));
  assign br_wait  = is_br && src1 != 5'd0 &&
                    ((ex_we && ex_rd == src1) || (mem_load && mem_we && mem_rd == src1));

  assign stall    = load_use || br_wait;
  assign bubble   = stall;
  assign redirect = is_br && id_cond_met && !stall;

  always_comb begin
    p_redirect_hold_r10: assert (!(redirect && stall));
    p_zero_dest_r5: assert (!(fwd_a != 2'b00 && ex_rs1 == 5'd0) && !(fwd_b != 2'b00 && ex_rs2 == 5'd0));
    if (mem_we && !mem_load && mem_rd == ex_rs1 && ex_rs1 != 5'd0)
      p_younger_wins_r3: assert (fwd_a == 2'b01);
    if (ex_load && ex_we && ex_rd != 5'd0 && op == OP_RR && ex_rd == src2)
      p_load_use_r6: assert (stall && bubble);
    if (!is_br && !ex_load)
      p_no_stall_r7: assert (!stall);
  end
endmodule

// File: tb/test_hazard_ctl.sv
module test_hazard_ctl;
  logic clk = 0;
  always #10 clk = ~clk;

  logic [31:0] id_instr;
  logic id_cond_met, ex_we, ex_load, mem_we, mem_load, wb_we;
  logic [4:0] ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic [1:0] fwd_a, fwd_b, fwd_z;
  logic stall, bubble, redirect;
  int checks = 0, failures = 0;
  bit done = 0;

  hazard_ctl i_hazard_ctl (.id_instr, .id_cond_met, .ex_rs1, .ex_rs2, .ex_rd, .ex_we,
    .ex_load, .mem_rd, .mem_we, .mem_load, .wb_rd, .wb_we, .fwd_a, .fwd_b, .fwd_z,
    .stall, .bubble, .redirect);

  function automatic logic [1:0] exp_sel(input logic [4:0] s);
    logic [1:0] r = 2'b00;
    if (wb_we && wb_rd == s) r = 2'b10;
    if (mem_we && !mem_load && mem_rd == s) r = 2'b01;
    if (s == 0) r = 2'b00;
    return r;
  endfunction

  function automatic logic exp_stall();
    logic [5:0] o = id_instr[31:26];
    logic [4:0] a = id_instr[25:21], b = id_instr[20:16];
    logic ua = !(o == 6'h02 || o == 6'h03);
    logic ub = (o == 6'h00 || o == 6'h2B);
    logic br = (o == 6'h04 || o == 6'h05);
    logic s = 0;
    if (ex_load && ex_we && ex_rd != 0 && ((ua && a == ex_rd) || (ub && b == ex_rd))) s = 1;
    if (br && a != 0 && ex_we && ex_rd == a) s = 1;
    if (br && a != 0 && mem_load && mem_we && mem_rd == a) s = 1;
    return s;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [4:0] a, input logic [4:0] b,
                       input logic cond, input logic [4:0] xr1, input logic [4:0] xr2,
                       input logic [4:0] xrd, input logic xwe, input logic xld,
                       input logic [4:0] mrd, input logic mwe, input logic mld,
                       input logic [4:0] wrd, input logic wwe);
    @(negedge clk);
    id_instr = {op, a, b, 16'h0041}; id_cond_met = cond;
    ex_rs1 = xr1; ex_rs2 = xr2; ex_rd = xrd; ex_we = xwe; ex_load = xld;
    mem_rd = mrd; mem_we = mwe; mem_load = mld; wb_rd = wrd; wb_we = wwe;
    #1;
  endtask

  task automatic check_all();
    logic es = exp_stall();
    logic br = (id_instr[31:26] == 6'h04 || id_instr[31:26] == 6'h05);
    chk("R1/R2/R3 fwd_a", fwd_a, exp_sel(ex_rs1));
    chk("R4 fwd_b", fwd_b, exp_sel(ex_rs2));
    chk("R9 fwd_z", fwd_z, exp_sel(id_instr[25:21]));
    chk("R6/R7/R8 stall", {1'b0, stall}, {1'b0, es});
    chk("R11 bubble", {1'b0, bubble}, {1'b0, es});
    chk("R10 redirect", {1'b0, redirect}, {1'b0, br && id_cond_met && !es});
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    // R11: quiet pipeline, nothing pending
    drive(6'h00, 5'd1, 5'd2, 0, 5'd1, 5'd2, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, 0);
    chk("R11 idle stall", {1'b0, stall}, 2'b00);
    chk("R1 idle fwd_a", fwd_a, 2'b00);
    // R1 EX/MEM forward
    drive(6'h00, 5'd9, 5'd9, 0, 5'd3, 5'd4, 5'd0, 0, 0, 5'd3, 1, 0, 5'd0, 0);
    chk("R1 fwd_a exmem", fwd_a, 2'b01);
    // R2 MEM/WB forward
    drive(6'h00, 5'd9, 5'd9, 0, 5'd3, 5'd4, 5'd0, 0, 0, 5'd0, 0, 0, 5'd3, 1);
    chk("R2 fwd_a memwb", fwd_a, 2'b10);
    // R3 both match: younger wins; R4 on b
    drive(6'h00, 5'd9, 5'd9, 0, 5'd6, 5'd6, 5'd0, 0, 0, 5'd6, 1, 0, 5'd6, 1);
    chk("R3 fwd_a priority", fwd_a, 2'b01);
    chk("R4 fwd_b priority", fwd_b, 2'b01);
    // R2: load in MEM is not a source; MEM/WB used instead
    drive(6'h00, 5'd9, 5'd9, 0, 5'd6, 5'd7, 5'd0, 0, 0, 5'd6, 1, 1, 5'd6, 1);
    chk("R2 load in mem skipped", fwd_a, 2'b10);
    // R5 register 0
    drive(6'h00, 5'd0, 5'd0, 0, 5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 5'd0, 1);
    chk("R5 zero fwd_a", fwd_a, 2'b00);
    chk("R5 zero stall", {1'b0, stall}, 2'b00);
    // R6 load-use on second source of reg-reg
    drive(6'h00, 5'd1, 5'd5, 0, 5'd0, 5'd0, 5'd5, 1, 1, 5'd0, 0, 0, 5'd0, 0);
    chk("R6 load-use stall", {1'b0, stall}, 2'b01);
    chk("R6 load-use bubble", {1'b0, bubble}, 2'b01);
    // R7 immediate op: bits 20:16 match load dest but not read
    drive(6'h08, 5'd1, 5'd5, 0, 5'd0, 5'd0, 5'd5, 1, 1, 5'd0, 0, 0, 5'd0, 0);
    chk("R7 unread field", {1'b0, stall}, 2'b00);
    // R7 jump never stalls
    drive(6'h02, 5'd5, 5'd5, 0, 5'd0, 5'd0, 5'd5, 1, 1, 5'd0, 0, 0, 5'd0, 0);
    chk("R7 jump", {1'b0, stall}, 2'b00);
    // R8 branch behind ALU writer, cond met: stall, no redirect
    drive(6'h04, 5'd7, 5'd0, 1, 5'd7, 5'd0, 5'd7, 1, 0, 5'd7, 1, 0, 5'd0, 0);
    chk("R8 branch wait ex", {1'b0, stall}, 2'b01);
    chk("R10 redirect held", {1'b0, redirect}, 2'b00);
    chk("R1 fwd during stall", fwd_a, 2'b01);
    // R8 branch behind load in MEM
    drive(6'h05, 5'd7, 5'd0, 1, 5'd0, 5'd0, 5'd0, 0, 0, 5'd7, 1, 1, 5'd0, 0);
    chk("R8 branch wait mem load", {1'b0, stall}, 2'b01);
    // R9 + R10: ALU result in MEM feeds compare, branch redirects
    drive(6'h05, 5'd7, 5'd0, 1, 5'd0, 5'd0, 5'd0, 0, 0, 5'd7, 1, 0, 5'd0, 0);
    chk("R9 fwd_z exmem", fwd_z, 2'b01);
    chk("R10 redirect", {1'b0, redirect}, 2'b01);
    chk("R10 no stall", {1'b0, stall}, 2'b00);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] ops [7] = '{6'h00, 6'h04, 6'h05, 6'h02, 6'h23, 6'h2B, 6'h08};
      drive(ops[$urandom % 7], 5'($urandom % 4), 5'($urandom % 4), 1'($urandom),
            5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4), 1'($urandom), 1'($urandom),
            5'($urandom % 4), 1'($urandom), 1'($urandom), 5'($urandom % 4), 1'($urandom));
      check_all();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule